// File: doc/BRIEF.md
# Reduced-Precision Floating-Point Add/Subtract Unit

This unit adds or subtracts two 23-bit floating-point numbers for an area-constrained audio transform datapath. The word packs a sign at bit 22, a 6-bit biased exponent at bits 21:16 (bias 31) and a 16-bit fraction at bits 15:0, with an implied leading one. An exponent field of zero means the value is zero. Infinities, NaNs and subnormals are not represented. The largest exponent field, 63, is an ordinary finite exponent.

Each operation passes through three combinational steps. The first orders the operands by magnitude, picks the result sign and exponent, and works out whether the fraction datapath must add or subtract; this depends on both operand signs and the select pin. The second combines the aligned significands. The third renormalizes the result into the packed word. A single output register holds the result.

Operands enter on a valid/ready handshake and results leave on another. A transfer happens on a rising clock edge where valid and ready are both high. The input side is ready whenever the output register is empty or its result is being taken in the same cycle. When the consumer holds `res_ready` low, the held result stays frozen and the input side stalls.

Top module: `fp23_addsub`

## Requirements
- R1: An operand whose exponent field (bits 21:16) is zero counts as zero whatever its fraction bits hold. A zero operand leaves the other operand as the result: with the select high it is negated, otherwise unchanged.
- R2: With `opd_sub` low the unit computes a+b, and with it high it computes a-b. The fraction datapath adds when the effective signs of a and b agree and subtracts when they differ.
- R3: The result sign is the effective sign of the operand with the larger magnitude. When the exponents are equal, the fractions decide which operand is larger.
- R4: The smaller significand is shifted right by the exponent difference, and the bits shifted out are dropped. A difference of 18 or more makes its contribution zero.
- R5: A carry out of the significand sum shifts the result right by one and raises the exponent by one. Leading zeros shift it left and lower the exponent by the same count. Bits lost in either shift are truncated.
- R6: If the normalized exponent would exceed 63, the result saturates to exponent 63 with fraction 0xFFFF, keeping the result sign.
- R7: An exact cancellation, or a normalized exponent of zero or below, gives +0 (all 23 bits zero).
- R8: A result is presented with `res_valid` high one clock after its operands are accepted. With no new operands accepted and `res_ready` high, `res_valid` falls after one clock.
- R9: While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` hold, `opd_ready` is low, and no new operands are taken.
- R10: During reset `res_valid` is low and `opd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opd_valid | input | 1 | Operands and select are valid |
| opd_ready | output | 1 | Unit accepts operands this cycle |
| opd_a | input | 23 | First operand |
| opd_b | input | 23 | Second operand |
| opd_sub | input | 1 | 1 selects a-b, 0 selects a+b |
| res_valid | output | 1 | Result register holds a result |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 23 | Packed result word |

## Verification
All arithmetic results are due exactly one rising edge after the operand transfer. The bench drives operands on a falling edge and compares `res_data` on the next falling edge, so one vector retires per cycle. The stall test keeps `res_ready` low across two further edges while new operands wait, and checks that the held word and the low `opd_ready` do not change. It then checks that the waiting operands appear one edge after `res_ready` returns high.

// File: rtl/fp23_pkg.sv
package fp23_pkg;
  localparam int EXP_W   = 6;
  localparam int MAN_W   = 16;
  localparam int WORD_W  = 1 + EXP_W + MAN_W;
  localparam int SIG_W   = MAN_W + 1;             // significand with hidden one
  localparam int RAW_W   = SIG_W + 1;             // plus carry
  localparam int LZ_W    = $clog2(SIG_W + 1);
  localparam int SHIFT_LIM = SIG_W + 1;           // shifts at or above this flush
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int EXT_W   = EXP_W + 2;             // signed exponent working width

  typedef struct packed {
    logic             sgn;
    logic [EXP_W-1:0] exp;
    logic [MAN_W-1:0] man;
  } fp_word_t;
endpackage

// File: rtl/fp23_prenorm.sv
module fp23_prenorm
  import fp23_pkg::*;
(
  input  fp_word_t         a_in,
  input  fp_word_t         b_in,
  input  logic             sub_sel,
  output logic [EXP_W-1:0] big_exp,
  output logic             big_sgn,
  output logic [SIG_W-1:0] big_sig,
  output logic [SIG_W-1:0] small_sig_al,
  output logic             do_sub
);
  logic [SIG_W-1:0] a_sig, b_sig, sm_sig;
  logic [EXP_W-1:0] sm_exp, diff;
  logic             b_sgn_eff, a_wins;

  always_comb begin
    // exponent zero means zero, fraction bits ignored
    a_sig     = (a_in.exp != '0) ? {1'b1, a_in.man} : '0;
    b_sig     = (b_in.exp != '0) ? {1'b1, b_in.man} : '0;
    b_sgn_eff = b_in.sgn ^ sub_sel;
    a_wins    = {a_in.exp, a_sig} >= {b_in.exp, b_sig};
    if (a_wins) begin
      big_exp = a_in.exp; big_sig = a_sig; big_sgn = a_in.sgn;
      sm_exp  = b_in.exp; sm_sig  = b_sig;
    end else begin
      big_exp = b_in.exp; big_sig = b_sig; big_sgn = b_sgn_eff;
      sm_exp  = a_in.exp; sm_sig  = a_sig;
    end
    diff   = big_exp - sm_exp;
    do_sub = a_in.sgn ^ b_sgn_eff;
    if (int'(diff) >= SHIFT_LIM) small_sig_al = '0;
    else                         small_sig_al = sm_sig >> diff;
  end
endmodule

// File: rtl/fp23_sig_addsub.sv
module fp23_sig_addsub
  import fp23_pkg::*;
(
  input  logic [SIG_W-1:0] big_sig,
  input  logic [SIG_W-1:0] small_sig,
  input  logic             do_sub,
  output logic [RAW_W-1:0] raw_sum
);
  always_comb begin
    if (do_sub) raw_sum = {1'b0, big_sig} - {1'b0, small_sig};
    else        raw_sum = {1'b0, big_sig} + {1'b0, small_sig};
  end
endmodule

// File: rtl/fp23_postnorm.sv
module fp23_postnorm
  import fp23_pkg::*;
(
  input  logic [RAW_W-1:0] raw_sum,
  input  logic [EXP_W-1:0] big_exp,
  input  logic             big_sgn,
  output fp_word_t         result
);
  logic [LZ_W-1:0]         lz;
  logic                    found;
  logic [SIG_W-1:0]        shifted;
  logic signed [EXT_W-1:0] e_n;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = SIG_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (raw_sum[i]) found = 1'b1;
        else            lz    = lz + 1'b1;
      end
    end
  end

  always_comb begin
    shifted = raw_sum[SIG_W-1:0] << lz;
    result  = '0;
    e_n     = '0;
    if (raw_sum == '0) begin
      result = '0;
    end else if (raw_sum[RAW_W-1]) begin
      e_n = $signed({2'b00, big_exp}) + 1;
      if (e_n > EXT_W'(EXP_MAX)) begin
        result = '{sgn: big_sgn, exp: '1, man: '1};
      end else begin
        result = '{sgn: big_sgn, exp: e_n[EXP_W-1:0], man: raw_sum[SIG_W-1:1]};
      end
    end else begin
      e_n = $signed({2'b00, big_exp}) - $signed({{(EXT_W-LZ_W){1'b0}}, lz});
      if (e_n <= 0) result = '0;
      else result = '{sgn: big_sgn, exp: e_n[EXP_W-1:0], man: shifted[MAN_W-1:0]};
    end
  end
endmodule

// File: rtl/fp23_addsub.sv
module fp23_addsub
  import fp23_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opd_valid,
  output logic              opd_ready,
  input  logic [WORD_W-1:0] opd_a,
  input  logic [WORD_W-1:0] opd_b,
  input  logic              opd_sub,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data
);
  logic [EXP_W-1:0] big_exp;
  logic             big_sgn, do_sub;
  logic [SIG_W-1:0] big_sig, small_sig_al;
  logic [RAW_W-1:0] raw_sum;
  fp_word_t         result;

  fp23_prenorm u_pre (
    .a_in(fp_word_t'(opd_a)), .b_in(fp_word_t'(opd_b)), .sub_sel(opd_sub),
    .big_exp(big_exp), .big_sgn(big_sgn), .big_sig(big_sig),
    .small_sig_al(small_sig_al), .do_sub(do_sub)
  );

  fp23_sig_addsub u_add (
    .big_sig(big_sig), .small_sig(small_sig_al), .do_sub(do_sub), .raw_sum(raw_sum)
  );

  fp23_postnorm u_post (
    .raw_sum(raw_sum), .big_exp(big_exp), .big_sgn(big_sgn), .result(result)
  );

  assign opd_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else if (opd_ready) begin
      res_valid <= opd_valid;
      if (opd_valid) res_data <= result;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));
  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    opd_valid && opd_ready |=> res_valid);
  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !opd_valid && res_ready |=> !res_valid);
  p_poszero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_data[WORD_W-2 -: EXP_W] == '0 |-> res_data == '0);
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !opd_ready);
endmodule

// File: tb/tb_fp23_addsub.sv
`timescale 1ns/1ps
module tb_fp23_addsub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opd_valid = 1'b0, opd_sub = 1'b0, res_ready = 1'b1;
  logic [22:0] opd_a = '0, opd_b = '0;
  logic        opd_ready, res_valid;
  logic [22:0] res_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fp23_addsub dut (
    .clk(clk), .rst_n(rst_n), .opd_valid(opd_valid), .opd_ready(opd_ready),
    .opd_a(opd_a), .opd_b(opd_b), .opd_sub(opd_sub),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  // {req, sub, a, b, expected}
  localparam int NV = 22;
  localparam logic [77:0] VEC [NV] = '{
    {8'd5, 1'b0, 23'h1F0000, 23'h1F0000, 23'h200000}, // R5 carry 1+1
    {8'd5, 1'b0, 23'h1F8000, 23'h1F8000, 23'h208000}, // R5 1.5+1.5
    {8'd2, 1'b1, 23'h200000, 23'h1F0000, 23'h1F0000}, // R2 2-1
    {8'd3, 1'b1, 23'h1F0000, 23'h200000, 23'h5F0000}, // R3 1-2
    {8'd7, 1'b0, 23'h1F0000, 23'h5F0000, 23'h000000}, // R7 cancel
    {8'd7, 1'b1, 23'h5F0000, 23'h5F0000, 23'h000000}, // R7 cancel neg
    {8'd2, 1'b0, 23'h5F0000, 23'h5F0000, 23'h600000}, // R2 -1+-1
    {8'd1, 1'b0, 23'h000000, 23'h1F8000, 23'h1F8000}, // R1 0+1.5
    {8'd1, 1'b1, 23'h1F8000, 23'h000000, 23'h1F8000}, // R1 1.5-0
    {8'd1, 1'b1, 23'h000000, 23'h1F0000, 23'h5F0000}, // R1 0-1
    {8'd1, 1'b0, 23'h00ABCD, 23'h1F0000, 23'h1F0000}, // R1 exp0 fraction ignored
    {8'd4, 1'b0, 23'h1F0000, 23'h0F0000, 23'h1F0001}, // R4 diff 16
    {8'd4, 1'b0, 23'h1F0000, 23'h0E0000, 23'h1F0000}, // R4 diff 17
    {8'd4, 1'b0, 23'h1F0000, 23'h0D0000, 23'h1F0000}, // R4 diff 18
    {8'd4, 1'b0, 23'h1F0000, 23'h1E0001, 23'h1F8000}, // R4 align truncation
    {8'd5, 1'b0, 23'h1F0001, 23'h1F0000, 23'h200000}, // R5 norm truncation
    {8'd6, 1'b0, 23'h3FFFFF, 23'h3FFFFF, 23'h3FFFFF}, // R6 saturate pos
    {8'd6, 1'b0, 23'h7FFFFF, 23'h7FFFFF, 23'h7FFFFF}, // R6 saturate neg
    {8'd7, 1'b1, 23'h010001, 23'h010000, 23'h000000}, // R7 underflow
    {8'd5, 1'b1, 23'h028000, 23'h020000, 23'h010000}, // R5 lands on exp 1
    {8'd3, 1'b1, 23'h1F0000, 23'h1F8000, 23'h5E0000}, // R3 equal exp, fraction decides
    {8'd3, 1'b0, 23'h608000, 23'h1F0000, 23'h600000}  // R3 -3+1
  };

  task automatic chk(input string req, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [22:0] a, input logic [22:0] b);
    opd_valid = 1'b1; opd_sub = s; opd_a = a; opd_b = b;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 res_valid", {22'd0, res_valid}, 23'd0);
    chk("R10 opd_ready", {22'd0, opd_ready}, 23'd1);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][69], VEC[i][68:46], VEC[i][45:23]);
      @(negedge clk);
      chk("R8 valid", {22'd0, res_valid}, 23'd1);
      chk($sformatf("R%0d vec %0d", VEC[i][77:70], i), res_data, VEC[i][22:0]);
    end
    opd_valid = 1'b0;
    @(negedge clk);
    chk("R8 drain", {22'd0, res_valid}, 23'd0);

    // R9 back-pressure
    res_ready = 1'b0;
    drive(1'b0, 23'h1F0000, 23'h1F0000);
    @(negedge clk);
    chk("R9 first", res_data, 23'h200000);
    chk("R9 ready low", {22'd0, opd_ready}, 23'd0);
    drive(1'b1, 23'h200000, 23'h1F0000);
    repeat (2) @(negedge clk);
    chk("R9 held data", res_data, 23'h200000);
    chk("R9 held valid", {22'd0, res_valid}, 23'd1);
    chk("R9 still stalled", {22'd0, opd_ready}, 23'd0);
    res_ready = 1'b1;
    @(negedge clk);
    chk("R9 released", res_data, 23'h1F0000);
    opd_valid = 1'b0;
    @(negedge clk);
    chk("R8 empty", {22'd0, res_valid}, 23'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule